// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A clocked front end for an external asynchronous static RAM of 8192 words by 9 bits. Internal logic issues single read or write requests over a valid/ready handshake. The controller sequences the memory's chip enables, output enable and write enable. One chip enable is active low and the other active high. It also steers a shared 9-bit data bus, split here into an output word, an output-enable and an input word so that the pad ring can build the tri-state buffer.

Each timing limit of the memory is converted at elaboration into a whole number of clock cycles, rounding up. The limits are access time, write-strobe width, data setup and output float time. Reads present address and enables, wait out the access count, capture the bus and return the word with a one-cycle strobe. Writes first hold the bus undriven for a turnaround window with output enable high. They then drive data and pulse write enable. The write ends by raising write enable while both chip enables stay asserted. Whenever no request is in progress, the memory is held deselected, which keeps it in its low-power state.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and immediately when it is asserted in the middle of an access, the outputs are mem_ce_n_o=1, mem_ce_o=0, mem_oe_n_o=1, mem_we_n_o=1, mem_dq_oe_o=0, req_ready_o=1 and rd_valid_o=0.
- R2: In every cycle where req_ready_o is high, the memory is deselected (mem_ce_n_o=1, mem_ce_o=0) with mem_oe_n_o=1, mem_we_n_o=1 and the data bus undriven.
- R3: A read accepted at a clock edge asserts mem_ce_n_o=0, mem_ce_o=1, mem_oe_n_o=0 and mem_we_n_o=1 with the bus undriven. ACC = ceil(T_AA_PS / CLK_PERIOD_PS) edges later, it captures mem_dq_i and raises rd_valid_o for exactly one cycle, with the word on rd_data_o.
- R4: A write accepted at an edge first spends TURN = max(1, ceil(T_HZOE_PS / CLK_PERIOD_PS)) cycles with both enables asserted, mem_oe_n_o=1, mem_we_n_o=1 and mem_dq_oe_o=0. mem_we_n_o then stays low for exactly WP = max(ceil(T_PWE_PS / CLK_PERIOD_PS), ceil(T_SD_PS / CLK_PERIOD_PS)) cycles.
- R5: mem_we_n_o rises while mem_ce_n_o=0, mem_ce_o=1 and the bus is still driven. Deselect follows one cycle later.
- R6: mem_dq_oe_o is never high while mem_oe_n_o is low. The driver turns on only after mem_oe_n_o has been high for at least one full cycle.
- R7: mem_we_n_o is low only while both chip enables are asserted. Throughout an access mem_addr_o holds the request address, and during the write strobe mem_dq_o holds the request data with the bus driven.
- R8: req_ready_o is low from the accept edge until the access completes: ACC cycles for a read, TURN+WP+1 cycles for a write.
- R9: A read returns the data most recently written to that address. This includes the lowest address 0 and the highest address 8191, and all-zero and all-one data.
- R10: rd_data_o keeps the last read word through any later write until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Word address |
| req_wdata_i | input | 9 | Write data |
| rd_valid_o | output | 1 | One-cycle read completion strobe |
| rd_data_o | output | 9 | Last captured read word |
| mem_addr_o | output | 13 | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_ce_o | output | 1 | Chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 9 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 9 | Data read from the memory bus |

## Verification
A sequencer stuck in the wrong state, or a cycle counter off by one, shows within the same access. Examples are a strobe one cycle short, a capture one edge early, or ready returning at the wrong cycle count. The bench memory model returns corrupted data until the access time has elapsed in real time, so an early capture appears as a wrong read word at the next rd_valid_o. A control register left set when the controller goes idle shows as a selected or driven bus in the first cycle that ready is high. A lost write shows only at the next read of that address, which the directed read-back sequences reach within a few accesses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_END
  } sram_state_e;

  function automatic int ceil_cycles(int t_ps, int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 3,
  parameter int WP_CYC   = 2,
  parameter int TURN_CYC = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             tmr_zero_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             ce_act_o,
  output logic             oe_act_o,
  output logic             we_act_o,
  output logic             drv_o
);
  localparam logic [CNT_W-1:0] AccLd  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WpLd   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TurnLd = CNT_W'(TURN_CYC - 1);

  sram_state_e state_q, state_d;
  logic ce_q, ce_d, oe_q, oe_d, we_q, we_d, drv_q, drv_d;

  always_comb begin
    state_d    = state_q;
    ce_d       = ce_q;
    oe_d       = oe_q;
    we_d       = we_q;
    drv_d      = drv_q;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o   = 1'b1;
        tmr_load_o = 1'b1;
        ce_d       = 1'b1;
        if (req_we_i) begin
          state_d   = ST_WR_TURN;
          tmr_val_o = TurnLd;
        end else begin
          state_d   = ST_RD_ACC;
          oe_d      = 1'b1;
          tmr_val_o = AccLd;
        end
      end
      ST_RD_ACC: if (tmr_zero_i) begin
        capture_o = 1'b1;
        state_d   = ST_IDLE;
        ce_d      = 1'b0;
        oe_d      = 1'b0;
      end
      ST_WR_TURN: if (tmr_zero_i) begin
        // bus has floated; drive data and open the strobe together
        state_d    = ST_WR_PULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WpLd;
        we_d       = 1'b1;
        drv_d      = 1'b1;
      end
      ST_WR_PULSE: if (tmr_zero_i) begin
        // terminate on write enable, enables and data held
        state_d = ST_WR_END;
        we_d    = 1'b0;
      end
      ST_WR_END: begin
        state_d = ST_IDLE;
        ce_d    = 1'b0;
        drv_d   = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        ce_d    = 1'b0;
        oe_d    = 1'b0;
        we_d    = 1'b0;
        drv_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      drv_q   <= drv_d;
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign ce_act_o = ce_q;
  assign oe_act_o = oe_q;
  assign we_act_o = we_q;
  assign drv_o    = drv_q;

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_q && oe_q)); // R6
  AST_DRV_AFTER_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $past(!oe_q)); // R6
  AST_WE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> ce_q); // R7
  AST_WR_END_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_q) |-> (ce_q && drv_q)); // R5
  AST_DESELECT_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_q) |=> (!ce_q && !drv_q)); // R5
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int AW = 13,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rd_valid_o = rvalid_q;
  assign rd_data_o  = rdata_q;

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_q |-> $stable(rdata_q)); // R10
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 13,
  parameter int DW            = 9,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_AA_PS       = 25000,
  parameter int T_PWE_PS      = 20000,
  parameter int T_SD_PS       = 15000,
  parameter int T_HZOE_PS     = 18000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int AccCyc  = ceil_cycles(T_AA_PS, CLK_PERIOD_PS);
  localparam int WpCyc   = max2(ceil_cycles(T_PWE_PS, CLK_PERIOD_PS),
                                ceil_cycles(T_SD_PS, CLK_PERIOD_PS));
  localparam int TurnCyc = ceil_cycles(T_HZOE_PS, CLK_PERIOD_PS);
  localparam int MaxCyc  = max2(AccCyc, max2(WpCyc, TurnCyc));
  localparam int CntW    = $clog2(MaxCyc + 1) + 1;

  logic accept, capture, tmr_load, tmr_zero;
  logic [CntW-1:0] tmr_val;
  logic ce_act, oe_act, we_act, drv;

  sram_ctrl_timer #(.CNT_W(CntW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_fsm #(
    .ACC_CYC (AccCyc),
    .WP_CYC  (WpCyc),
    .TURN_CYC(TurnCyc),
    .CNT_W   (CntW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .tmr_zero_i (tmr_zero),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .ce_act_o   (ce_act),
    .oe_act_o   (oe_act),
    .we_act_o   (we_act),
    .drv_o      (drv)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  // both enables come from one register so they never disagree
  assign mem_ce_n_o  = ~ce_act;
  assign mem_ce_o    = ce_act;
  assign mem_oe_n_o  = ~oe_act;
  assign mem_we_n_o  = ~we_act;
  assign mem_dq_oe_o = drv;

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_n_o && !mem_ce_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o)); // R7
  AST_RD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_ce_n_o && mem_ce_o)); // R3
endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int PER_PS  = 8000;
  localparam int TAA_PS  = 25000;
  localparam int TPWE_PS = 20000;
  localparam int TSD_PS  = 15000;
  localparam int THZ_PS  = 18000;

  function automatic int cdiv(int a, int b);
    int n;
    n = (a + b - 1) / b;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int ACC  = cdiv(TAA_PS, PER_PS);
  localparam int WP   = (cdiv(TPWE_PS, PER_PS) > cdiv(TSD_PS, PER_PS)) ?
                        cdiv(TPWE_PS, PER_PS) : cdiv(TSD_PS, PER_PS);
  localparam int TURN = cdiv(THZ_PS, PER_PS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [12:0] req_addr_i = '0;
  logic [8:0]  req_wdata_i = '0;
  logic req_ready_o, rd_valid_o, mem_ce_n_o, mem_ce_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o;
  logic [8:0]  rd_data_o, mem_dq_o;
  logic [8:0]  mem_dq_i = 9'h155;
  logic [12:0] mem_addr_o;

  int checks = 0, errors = 0, cycles = 0, rd_age = 0, we_low = 0;
  bit done = 1'b0;
  logic [8:0] model_mem [int];
  logic [8:0] exp_mem [int];

  always #4 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_PS(PER_PS), .T_AA_PS(TAA_PS), .T_PWE_PS(TPWE_PS),
              .T_SD_PS(TSD_PS), .T_HZOE_PS(THZ_PS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .mem_addr_o(mem_addr_o),
    .mem_ce_n_o(mem_ce_n_o), .mem_ce_o(mem_ce_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i));

  function automatic logic [8:0] dflt(logic [12:0] a);
    return a[8:0] ^ 9'h0A5 ^ {a[12:9], 5'b10011};
  endfunction

  function automatic logic [8:0] model_rd(logic [12:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : dflt(a);
  endfunction

  function automatic logic [8:0] exp_rd(logic [12:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: data only valid once the access time has elapsed
  always @(negedge clk) begin
    if (!mem_ce_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o) begin
      rd_age++;
      if (rd_age * PER_PS - PER_PS / 2 >= TAA_PS) mem_dq_i = model_rd(mem_addr_o);
      else mem_dq_i = ~model_rd(mem_addr_o);
    end else begin
      rd_age = 0;
      mem_dq_i = 9'h155;
    end
  end

  always @(posedge mem_we_n_o) begin
    if (rst_ni === 1'b1) begin
      chk("R5 enables+drive at write end", {mem_ce_n_o, mem_ce_o, mem_dq_oe_o}, 3'b011);
      if (!mem_ce_n_o && mem_ce_o) model_mem[int'(mem_addr_o)] = mem_dq_o;
    end
  end

  // port-level protocol monitors
  logic prev_oe_n = 1'b1, prev_dqoe = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (req_ready_o)
        chk("R2 idle deselect", {mem_ce_n_o, mem_ce_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o}, 5'b10110);
      if (mem_dq_oe_o && !mem_oe_n_o) chk("R6 contention", 1, 0);
      if (mem_dq_oe_o && !prev_dqoe) chk("R6 oe high before drive", {prev_oe_n, mem_oe_n_o}, 2'b11);
      if (!mem_we_n_o) begin
        we_low++;
        if (mem_ce_n_o || !mem_ce_o) chk("R7 we under ce", 1, 0);
      end else if (we_low != 0) begin
        chk("R4 strobe width", we_low, WP);
        we_low = 0;
      end
    end
    prev_oe_n = mem_oe_n_o;
    prev_dqoe = mem_dq_oe_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_write(logic [12:0] a, logic [8:0] d);
    int n = 0, we_at = -1;
    bit turn_ok = 1'b1, wr_ok = 1'b1;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    do begin
      @(negedge clk);
      if (n == 0) begin req_valid_i = 1'b0; req_addr_i = ~a; req_wdata_i = ~d; end
      n++;
      if (!mem_we_n_o && we_at < 0) we_at = n - 1;
      if (we_at < 0 && !req_ready_o &&
          !(!mem_ce_n_o && mem_ce_o && mem_oe_n_o && !mem_dq_oe_o)) turn_ok = 1'b0;
      if (!mem_we_n_o && !(mem_addr_o == a && mem_dq_o == d && mem_dq_oe_o)) wr_ok = 1'b0;
    end while (!req_ready_o);
    chk("R4 turnaround length", we_at, TURN);
    chk("R4 turnaround state", turn_ok, 1);
    chk("R7 addr/data during strobe", wr_ok, 1);
    chk("R8 write busy cycles", n - 1, TURN + WP + 1);
    exp_mem[int'(a)] = d;
  endtask

  task automatic do_read(logic [12:0] a, string tag);
    int n = 0, rv_at = -1;
    bit ctl_ok = 1'b1;
    logic [8:0] got = '0;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = a;
    do begin
      @(negedge clk);
      if (n == 0) begin req_valid_i = 1'b0; req_addr_i = ~a; end
      n++;
      if (rd_valid_o && rv_at < 0) begin rv_at = n - 1; got = rd_data_o; end
      if (!req_ready_o && !(!mem_ce_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o &&
          !mem_dq_oe_o && mem_addr_o == a)) ctl_ok = 1'b0;
    end while (!req_ready_o);
    chk("R3 read controls", ctl_ok, 1);
    chk("R3 rd_valid cycle", rv_at, ACC);
    chk({tag, " read data"}, got, exp_rd(a));
    chk("R8 read busy cycles", n - 1, ACC);
    @(negedge clk);
    chk("R3 rd_valid single pulse", rd_valid_o, 0);
  endtask

  initial begin
    logic [8:0] last;
    void'($urandom(32'd4711));
    #20;
    chk("R1 reset controls", {mem_ce_n_o, mem_ce_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o}, 5'b10110);
    chk("R1 reset handshake", {req_ready_o, rd_valid_o}, 2'b10);
    @(negedge clk); rst_ni = 1'b1;

    // directed corners
    do_write(13'h0000, 9'h1FF);
    do_write(13'h1FFF, 9'h000);
    do_read(13'h0000, "R9 low addr");
    do_read(13'h1FFF, "R9 high addr");
    do_read(13'h0ABC, "R9 unwritten");
    do_read(13'h0ABC, "R9 back-to-back");
    do_write(13'h0ABC, 9'h0C3);
    do_read(13'h0ABC, "R9 read after write");
    last = rd_data_o;
    do_write(13'h0ABC, 9'h13C);
    do_write(13'h0001, 9'h055);
    chk("R10 rd_data holds over writes", rd_data_o, last);

    // reset in the middle of a read
    @(negedge clk);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = 13'h0001;
    @(negedge clk); req_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0; #1;
    chk("R1 mid-access reset", {mem_ce_n_o, mem_ce_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o,
        req_ready_o, rd_valid_o}, 7'b1011010);
    @(negedge clk); rst_ni = 1'b1;
    do_read(13'h0001, "R9 after reset");

    // constrained random mix in two address windows
    for (int i = 0; i < 150; i++) begin
      logic [12:0] a;
      a = 13'($urandom % 24) | (($urandom % 2) ? 13'h1FE0 : 13'h0000);
      if ($urandom % 2) do_write(a, 9'($urandom));
      else do_read(a, "R9 random");
    end
    last = rd_data_o;
    do_write(13'h1FE3, 9'h0F0);
    chk("R10 rd_data after random", rd_data_o, last);
    do_read(13'h1FE3, "R9 final");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule